// File: doc/BRIEF.md
# Power Control Reset Sequencer

This block turns a one-byte power control command into timed reset activity for the rest of the system. It drives three active-low reset outputs (core, secondary and memory), a latched power-off request and a latched sleep notice. Each reboot-type command bit selects its own group of resets. The normal reboot also pulls the memory reset when the legacy-mode input is high.

Once a write selects at least one reset, the block holds the selected resets low for a fixed number of clock cycles and then releases them all in the same cycle. It then waits a longer settle interval and raises a one-cycle reinitialise strobe towards the register file. `busy` is high for the whole sequence, and any command presented during that time is dropped. Both intervals are parameters given in clock cycles. At a 100 MHz clock, 500,000 cycles give the 5 ms hold and 10,000,000 cycles give the 100 ms settle.

Top module: `pwr_rst_seq`

## Requirements
- R1: Out of reset, all three reset outputs are high (deasserted), and `busy`, `reinit`, `pwroff_req` and `sleep_flag` are all low.
- R2: Command bits 7:5 have no effect. A write with only those bits set starts no sequence and sets no flag.
- R3: Bit 0 sets `pwroff_req` in the cycle after an accepted write. The request stays high until `rst_n` and starts no reset sequence.
- R4: Bit 1 (full reboot) asserts the core, secondary and memory resets.
- R5: Bit 2 (normal reboot) asserts the secondary reset. It also asserts the memory reset only if `legacy_mode` is high in the write cycle.
- R6: Bit 3 asserts only the memory reset.
- R7: When several reset bits are written together, the union of their reset groups is asserted.
- R8: The selected resets go low in the cycle after the accepted write and stay low for exactly HOLD_CYCLES cycles. All of them then rise in the same cycle, and unselected resets stay high throughout.
- R9: Exactly SETTLE_CYCLES cycles after the release, `reinit` is high for a single cycle.
- R10: `busy` is high from the cycle after an accepted reset write through the `reinit` cycle. Writes presented while `busy` is high change no output.
- R11: Bit 4 sets `sleep_flag`, which stays high until `rst_n`. The command bit itself does not persist, and it starts no sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command write strobe, one cycle per write |
| cmd_data | input | CMD_W | Power control command byte |
| legacy_mode | input | 1 | High when the system runs in legacy mode |
| core_rst_n | output | 1 | Core reset, active low |
| sec_rst_n | output | 1 | Secondary reset, active low |
| mem_rst_n | output | 1 | Memory reset, active low |
| pwroff_req | output | 1 | Latched power-off request |
| sleep_flag | output | 1 | Latched imminent-sleep notice |
| busy | output | 1 | High while a reset sequence runs |
| reinit | output | 1 | One-cycle reinitialise strobe to the register file |

## Verification
The bench builds the block with HOLD_CYCLES = 12 and SETTLE_CYCLES = 30 in place of the millisecond-scale defaults. With these values every full sequence takes a few dozen cycles. The bench can therefore count the hold and settle windows cycle by cycle, for each reset subset and both legacy settings. The short hold also lets a command be injected inside the hold window, which checks that writes are ignored while `busy` is high.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    // Sequence phase
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_HOLD   = 2'd1,
        PH_SETTLE = 2'd2,
        PH_REINIT = 2'd3
    } phase_e;

    // Reset selection, 1 = assert that reset
    typedef struct packed {
        logic core;
        logic sec;
        logic mem;
    } rst_sel_t;

    // Command bit positions
    localparam int unsigned BIT_PWROFF = 0;
    localparam int unsigned BIT_FULL   = 1;
    localparam int unsigned BIT_NORMAL = 2;
    localparam int unsigned BIT_MEM    = 3;
    localparam int unsigned BIT_SLEEP  = 4;
    localparam int unsigned LIVE_BITS  = 5;

endpackage

// File: rtl/pwr_cmd_decode.sv
module pwr_cmd_decode
    import pwr_seq_pkg::*;
#(
    parameter int unsigned CMD_W = 8
) (
    input  logic [CMD_W-1:0] cmd,
    input  logic             legacy,
    output rst_sel_t         sel,
    output logic             pwroff,
    output logic             sleep
);
    localparam logic [CMD_W-1:0] LIVE_MASK = CMD_W'((1 << LIVE_BITS) - 1);

    logic [CMD_W-1:0] cmd_m;

    always_comb begin
        cmd_m    = cmd & LIVE_MASK;
        pwroff   = cmd_m[BIT_PWROFF];
        sleep    = cmd_m[BIT_SLEEP];
        sel.core = cmd_m[BIT_FULL];
        sel.sec  = cmd_m[BIT_FULL] | cmd_m[BIT_NORMAL];
        sel.mem  = cmd_m[BIT_FULL] | cmd_m[BIT_MEM]
                 | (cmd_m[BIT_NORMAL] & legacy);
    end

    // R4: a full reboot always selects every reset
    always_comb begin
        if (cmd_m[BIT_FULL])
            a_full_all_r4: assert (sel.core && sel.sec && sel.mem);
    end

endmodule

// File: rtl/pwr_seq_timer.sv
module pwr_seq_timer
    import pwr_seq_pkg::*;
#(
    parameter int unsigned HOLD_CYCLES   = 500_000,
    parameter int unsigned SETTLE_CYCLES = 10_000_000
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    output phase_e phase,
    output logic   release_now,
    output logic   reinit
);
    localparam int unsigned MAX_CYC = (HOLD_CYCLES > SETTLE_CYCLES) ? HOLD_CYCLES : SETTLE_CYCLES;
    localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] HOLD_LD   = CNT_W'(HOLD_CYCLES - 1);
    localparam logic [CNT_W-1:0] SETTLE_LD = CNT_W'(SETTLE_CYCLES - 1);

    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        release_now = 1'b0;
        unique case (st_q.ph)
            PH_IDLE: begin
                if (start) begin
                    st_d.ph  = PH_HOLD;
                    st_d.cnt = HOLD_LD;
                end
            end
            PH_HOLD: begin
                if (st_q.cnt == '0) begin
                    release_now = 1'b1;
                    st_d.ph     = PH_SETTLE;
                    st_d.cnt    = SETTLE_LD;
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            PH_SETTLE: begin
                if (st_q.cnt == '0) st_d.ph = PH_REINIT;
                else                st_d.cnt = st_q.cnt - 1'b1;
            end
            PH_REINIT: begin
                st_d.ph  = PH_IDLE;
                st_d.cnt = '0;
            end
            default: st_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign phase  = st_q.ph;
    assign reinit = (st_q.ph == PH_REINIT);

    // R9: strobe lasts one cycle and ends the sequence
    p_reinit_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        reinit |=> (phase == PH_IDLE));
    // R9: reinit is only ever reached from the settle phase
    p_reinit_after_settle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reinit) |-> ($past(phase) == PH_SETTLE));
    // R8: hold phase only exits to settle
    p_hold_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_HOLD) |=> (phase == PH_HOLD || phase == PH_SETTLE));

endmodule

// File: rtl/pwr_rst_drive.sv
module pwr_rst_drive
    import pwr_seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     load,
    input  rst_sel_t sel,
    input  logic     release_now,
    output logic     core_rst_n,
    output logic     sec_rst_n,
    output logic     mem_rst_n
);
    rst_sel_t act_d, act_q;

    always_comb begin
        act_d = act_q;
        if (release_now) act_d = '0;
        else if (load)   act_d = sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) act_q <= '0;
        else        act_q <= act_d;
    end

    assign core_rst_n = ~act_q.core;
    assign sec_rst_n  = ~act_q.sec;
    assign mem_rst_n  = ~act_q.mem;

    // R8: whenever any reset rises, all of them are high
    p_release_together_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(core_rst_n) || $rose(sec_rst_n) || $rose(mem_rst_n))
            |-> (core_rst_n && sec_rst_n && mem_rst_n));

endmodule

// File: rtl/pwr_rst_seq.sv
module pwr_rst_seq
    import pwr_seq_pkg::*;
#(
    parameter int unsigned CMD_W         = 8,
    parameter int unsigned HOLD_CYCLES   = 500_000,
    parameter int unsigned SETTLE_CYCLES = 10_000_000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [CMD_W-1:0] cmd_data,
    input  logic             legacy_mode,
    output logic             core_rst_n,
    output logic             sec_rst_n,
    output logic             mem_rst_n,
    output logic             pwroff_req,
    output logic             sleep_flag,
    output logic             busy,
    output logic             reinit
);
    typedef struct packed {
        logic pwroff;
        logic sleep;
    } flags_t;

    rst_sel_t sel;
    logic     dec_pwroff, dec_sleep;
    phase_e   phase;
    logic     release_now;
    logic     accept, start;
    flags_t   fl_d, fl_q;

    pwr_cmd_decode #(.CMD_W(CMD_W)) u_dec (
        .cmd    (cmd_data),
        .legacy (legacy_mode),
        .sel    (sel),
        .pwroff (dec_pwroff),
        .sleep  (dec_sleep)
    );

    always_comb begin
        accept = cmd_valid && (phase == PH_IDLE);
        start  = accept && (|sel);
        fl_d   = fl_q;
        if (accept) begin
            fl_d.pwroff = fl_q.pwroff | dec_pwroff;
            fl_d.sleep  = fl_q.sleep  | dec_sleep;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    pwr_seq_timer #(
        .HOLD_CYCLES   (HOLD_CYCLES),
        .SETTLE_CYCLES (SETTLE_CYCLES)
    ) u_tmr (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .phase       (phase),
        .release_now (release_now),
        .reinit      (reinit)
    );

    pwr_rst_drive u_drv (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (start),
        .sel         (sel),
        .release_now (release_now),
        .core_rst_n  (core_rst_n),
        .sec_rst_n   (sec_rst_n),
        .mem_rst_n   (mem_rst_n)
    );

    assign busy       = (phase != PH_IDLE);
    assign pwroff_req = fl_q.pwroff;
    assign sleep_flag = fl_q.sleep;

    // R10: any asserted reset implies a running sequence
    p_reset_in_seq_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(core_rst_n && sec_rst_n && mem_rst_n) |-> busy);
    // R10: writes during busy leave the flags untouched
    p_ignore_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_valid) |=> ($stable(pwroff_req) && $stable(sleep_flag)));
    // R3: power-off request is sticky
    p_pwroff_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pwroff_req |=> pwroff_req);
    // R11: sleep notice is sticky
    p_sleep_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_flag |=> sleep_flag);

endmodule

// File: tb/pwr_rst_seq_tb_top.sv
module pwr_rst_seq_tb_top;

    localparam int unsigned HOLD   = 12;
    localparam int unsigned SETTLE = 30;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [7:0] cmd_data = '0;
    logic       legacy_mode = 1'b0;
    logic       core_rst_n, sec_rst_n, mem_rst_n;
    logic       pwroff_req, sleep_flag, busy, reinit;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pwr_rst_seq #(
        .CMD_W(8), .HOLD_CYCLES(HOLD), .SETTLE_CYCLES(SETTLE)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
        .legacy_mode(legacy_mode), .core_rst_n(core_rst_n), .sec_rst_n(sec_rst_n),
        .mem_rst_n(mem_rst_n), .pwroff_req(pwroff_req), .sleep_flag(sleep_flag),
        .busy(busy), .reinit(reinit)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive a command for one cycle; returns at the negedge after the accepting edge
    task automatic write_cmd(input logic [7:0] c, input logic leg);
        @(negedge clk);
        cmd_valid   = 1'b1;
        cmd_data    = c;
        legacy_mode = leg;
        @(negedge clk);
        cmd_valid   = 1'b0;
        cmd_data    = '0;
    endtask

    // Run a reset sequence and check pattern, hold, settle and strobe
    task automatic run_seq(input logic [7:0] c, input logic leg, input logic [2:0] exp_low,
                           input string req, input bit inject);
        int hold_n = 0;
        int settle_n = 0;
        bit pat_ok = 1'b1;
        bit side_ok = 1'b1;
        logic [2:0] low;
        logic pw0 = pwroff_req;
        write_cmd(c, leg);
        chk(busy == 1'b1, {req, " busy after write (R10)"}, busy, 1);
        low = {~core_rst_n, ~sec_rst_n, ~mem_rst_n};
        chk(low == exp_low, {req, " reset subset"}, low, exp_low);
        while (low != 3'b000 && hold_n < 1000) begin
            if (low != exp_low) pat_ok = 1'b0;
            hold_n++;
            if (inject && hold_n == 3) begin
                cmd_valid = 1'b1; cmd_data = 8'h03;
            end else begin
                cmd_valid = 1'b0; cmd_data = '0;
            end
            @(negedge clk);
            low = {~core_rst_n, ~sec_rst_n, ~mem_rst_n};
        end
        cmd_valid = 1'b0;
        chk(pat_ok, {req, " subset stable during hold (R8)"}, pat_ok, 1);
        chk(hold_n == HOLD, {req, " hold length (R8)"}, hold_n, HOLD);
        while (busy && !reinit && settle_n < 1000) begin
            if (!(core_rst_n && sec_rst_n && mem_rst_n)) side_ok = 1'b0;
            settle_n++;
            @(negedge clk);
        end
        chk(side_ok, {req, " all released in settle (R8)"}, side_ok, 1);
        chk(settle_n == SETTLE, {req, " settle length (R9)"}, settle_n, SETTLE);
        chk(reinit == 1'b1 && busy == 1'b1, {req, " reinit strobe (R9)"}, reinit, 1);
        @(negedge clk);
        chk(reinit == 1'b0 && busy == 1'b0, {req, " sequence ends (R10)"}, busy, 0);
        if (inject) begin
            chk(pwroff_req == pw0, "R10 injected write ignored, pwroff", pwroff_req, pw0);
            repeat (3) @(negedge clk);
            chk(busy == 1'b0 && core_rst_n, "R10 no new sequence after ignored write", busy, 0);
        end
    endtask

    task automatic test_reset_state();
        chk(core_rst_n && sec_rst_n && mem_rst_n, "R1 resets high", {core_rst_n, sec_rst_n, mem_rst_n}, 7);
        chk(!busy && !reinit, "R1 busy/reinit low", {busy, reinit}, 0);
        chk(!pwroff_req && !sleep_flag, "R1 flags low", {pwroff_req, sleep_flag}, 0);
    endtask

    task automatic test_mask();
        write_cmd(8'hE0, 1'b1);
        chk(!busy, "R2 upper bits start nothing", busy, 0);
        chk(!pwroff_req && !sleep_flag, "R2 upper bits set no flag", {pwroff_req, sleep_flag}, 0);
        chk(core_rst_n && sec_rst_n && mem_rst_n, "R2 resets stay high", {core_rst_n, sec_rst_n, mem_rst_n}, 7);
    endtask

    task automatic test_sleep();
        write_cmd(8'h10, 1'b0);
        chk(sleep_flag == 1'b1, "R11 sleep flag set", sleep_flag, 1);
        chk(!busy, "R11 no sequence", busy, 0);
        repeat (4) @(negedge clk);
        chk(sleep_flag == 1'b1, "R11 sleep flag sticky", sleep_flag, 1);
    endtask

    task automatic test_pwroff();
        write_cmd(8'h01, 1'b0);
        chk(pwroff_req == 1'b1, "R3 power-off set", pwroff_req, 1);
        chk(!busy && core_rst_n && sec_rst_n && mem_rst_n, "R3 no reset sequence", busy, 0);
        repeat (4) @(negedge clk);
        chk(pwroff_req == 1'b1, "R3 power-off sticky", pwroff_req, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset_state();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset_state();
        test_mask();
        // subset encoding {core, sec, mem}
        run_seq(8'h02, 1'b0, 3'b111, "R4 full", 1'b0);
        run_seq(8'h04, 1'b0, 3'b010, "R5 normal non-legacy", 1'b0);
        run_seq(8'h04, 1'b1, 3'b011, "R5 normal legacy", 1'b0);
        run_seq(8'h08, 1'b1, 3'b001, "R6 memory only", 1'b1);
        run_seq(8'h0C, 1'b0, 3'b011, "R7 union normal+mem", 1'b0);
        run_seq(8'hE6, 1'b0, 3'b111, "R7 union full+normal, R2 upper ignored", 1'b0);
        test_sleep();
        test_pwroff();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule